// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block is a machine-level timer that serves several harts. It keeps one 64-bit time counter and, for each hart, a 64-bit compare value. Every hart has its own level interrupt output. That output is high while the hart's compare value is at or below the counter, in unsigned terms. The counter advances by one on every clock in which the external tick-enable input is high. Software can reach both the counter and the compare values through a single-cycle register port with little-endian layout. Each access is 4 or 8 bytes wide.

The compare slots start at a parameterised compare base and sit 8 bytes apart. The counter sits at a separate parameterised time address. A 4-byte write reaches one half of a register and leaves the other half as it was, so a 32-bit host can update a 64-bit value in two steps. The register port has no handshake: every request completes in the cycle it is presented, so there is no back-pressure. Read data is combinational from the address that is currently presented.

Top module: `mhart_timer`

## Requirements
- R1: After reset the counter reads zero, every compare value reads all-ones, and every interrupt output is low.
- R2: The counter increments by one, with carry across the 32-bit halves, on each clock where `tick_en` is high and no counter write occurs. It holds when `tick_en` is low.
- R3: A counter write and a tick in the same cycle leave the written value in the counter; the tick is lost.
- R4: Counter writes follow these rules (`bus_size` 0 = 4 bytes, 1 = 8 bytes). A 4-byte write at time address +0 replaces bits 31:0, and a 4-byte write at +4 replaces bits 63:32; in both cases the other half is kept. An 8-byte write at +0 replaces all 64 bits. An 8-byte write at +4 has no effect.
- R5: The compare register of hart h sits at compare base + 8*h. An address whose slot index is NUM_HARTS or above reads zero, and a write to it changes no register.
- R6: Compare writes follow the same half rules as R4. A 4-byte write at slot offset 0 replaces the low half, and a 4-byte write at offset 4 replaces the high half. An 8-byte write at offset 0 replaces the whole value. An 8-byte write at offset 4 is ignored.
- R7: Interrupt h is high exactly when compare h is unsigned less than or equal to the counter. The output is registered, so it reflects register values one clock after they change.
- R8: After a counter write, every hart's interrupt is re-evaluated against the new counter value.
- R9: A read at an offset other than 0 or 4 within a slot, or at an address outside both regions, returns zero. A write there has no effect.
- R10: At offset 0, a 4-byte read returns the low half zero-extended and an 8-byte read returns the full value. A read at offset 4 returns the high half in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase enable, advances the counter |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 0 = 4-byte access, 1 = 8-byte access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data; a 4-byte write uses bits 31:0 |
| bus_rdata | output | 64 | Read data, zero unless a read is presented |
| timer_irq | output | NUM_HARTS | Per-hart level timer interrupt |

## Verification
The counter is stepped through idle stretches, ticking stretches, a carry out of the low half, and a write made in the same cycle as a tick. Together these separate plain increment, hold, carry propagation and write priority. Split 4-byte writes are paired with 8-byte writes, including the ignored 8-byte write at the high offset, so that half merging can be told apart from whole replacement. Compare values are placed just below, at, above and sign-straddling the counter. This exposes off-by-one and signed-compare errors. Whole-counter jumps in both directions show whether all harts are re-evaluated together. Out-of-range slots, odd offsets and unmapped addresses are written and then read back, together with the real slots, to prove that nothing was disturbed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W  = 64;
  localparam int HALF_W = REG_W / 2;

  typedef enum logic {ACC_W32 = 1'b0, ACC_W64 = 1'b1} acc_size_e;

  // one-hot-or-none write decode of a 64-bit register
  typedef struct packed {
    logic lo;
    logic full;
    logic hi;
  } half_wr_t;

  function automatic half_wr_t split_write(logic hit, logic we,
                                           logic [2:0] sub, logic sz);
    half_wr_t r;
    r = '0;
    if (hit && we) begin
      if (sub == 3'd0) begin
        if (sz == ACC_W64) r.full = 1'b1;
        else               r.lo   = 1'b1;
      end else if (sub == 3'd4 && sz == ACC_W32) begin
        r.hi = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] read_view(logic [REG_W-1:0] v,
                                                 logic [2:0] sub, logic sz);
    logic [REG_W-1:0] r;
    case (sub)
      3'd0:    r = (sz == ACC_W64) ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
      3'd4:    r = {{HALF_W{1'b0}}, v[REG_W-1:HALF_W]};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_reg64.sv
module tmr_reg64
  import tmr_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  half_wr_t         wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tick,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= RST_VAL;
    else if (wr.full) q <= wdata;
    else if (wr.lo)   q <= {q[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
    else if (wr.hi)   q <= {wdata[HALF_W-1:0], q[HALF_W-1:0]};
    else if (tick)    q <= q + 1'b1;
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr == '0 && tick) |=> q == $past(q) + 64'd1);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr == '0 && !tick) |=> $stable(q));
  // R3
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.full |=> q == $past(wdata));
endmodule

// File: rtl/tmr_hart_unit.sv
module tmr_hart_unit
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  half_wr_t         wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] time_now,
  output logic [REG_W-1:0] cmp_val,
  output logic             irq
);
  tmr_reg64 #(.RST_VAL({REG_W{1'b1}})) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr),
    .wdata (wdata),
    .tick  (1'b0),
    .q     (cmp_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (cmp_val <= time_now);
  end

  // R7
  fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val <= time_now && $stable(cmp_val) && $stable(time_now)) |-> irq);
  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val > time_now && $stable(cmp_val) && $stable(time_now)) |-> !irq);
endmodule

// File: rtl/mhart_timer.sv
module mhart_timer
  import tmr_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 12,
  parameter int CMP_BASE  = 'h000,
  parameter int TIME_BASE = 'hFF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic                 bus_size,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam logic [ADDR_W-1:0] CMP_A  = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] TIME_A = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_HARTS * 8);

  logic [ADDR_W-1:0]    cmp_off;
  logic [2:0]           sub;
  logic                 in_cmp, in_time;
  logic [NUM_HARTS-1:0] slot_hit;
  logic [REG_W-1:0]     time_q;
  logic [REG_W-1:0]     cmp_val [NUM_HARTS];
  half_wr_t             time_wr;

  assign cmp_off = bus_addr - CMP_A;
  assign sub     = bus_addr[2:0];
  assign in_cmp  = bus_en && (bus_addr >= CMP_A) && (cmp_off < SPAN_A);
  assign in_time = bus_en && (bus_addr[ADDR_W-1:3] == TIME_A[ADDR_W-1:3]);
  assign time_wr = split_write(in_time, bus_we, sub, bus_size);

  tmr_reg64 #(.RST_VAL('0)) u_time (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (time_wr),
    .wdata (bus_wdata),
    .tick  (tick_en),
    .q     (time_q)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign slot_hit[h] = in_cmp && (cmp_off[ADDR_W-1:3] == (ADDR_W-3)'(h));
    tmr_hart_unit u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (split_write(slot_hit[h], bus_we, sub, bus_size)),
      .wdata    (bus_wdata),
      .time_now (time_q),
      .cmp_val  (cmp_val[h]),
      .irq      (timer_irq[h])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (in_time) bus_rdata = read_view(time_q, sub, bus_size);
      for (int h = 0; h < NUM_HARTS; h++)
        if (slot_hit[h]) bus_rdata = read_view(cmp_val[h], sub, bus_size);
    end
  end

  // R5
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !in_cmp && !in_time) |-> bus_rdata == '0);
endmodule

// File: tb/mhart_timer_test.sv
module mhart_timer_test;
  localparam int N   = 4;
  localparam int AW  = 12;
  localparam logic [AW-1:0] CB = 12'h000;
  localparam logic [AW-1:0] TB = 12'hFF8;
  localparam logic [63:0] ONES = {64{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, bus_en = 1'b0, bus_we = 1'b0, bus_size = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [63:0]   bus_wdata = '0;
  logic [63:0]   bus_rdata;
  logic [N-1:0]  timer_irq;

  int vectors = 0;
  int fails   = 0;

  logic [63:0] tm;
  logic [63:0] cm [N];
  logic [N-1:0] irq_m;

  always #10 clk = ~clk;

  mhart_timer #(.NUM_HARTS(N), .ADDR_W(AW), .CMP_BASE(0), .TIME_BASE('hFF8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_irq(timer_irq)
  );

  function automatic logic [63:0] m_read(logic [AW-1:0] a, logic sz);
    logic [63:0] v;
    if (a >= CB && a < CB + AW'(N * 8)) v = cm[(a - CB) >> 3];
    else if (a[AW-1:3] == TB[AW-1:3]) v = tm;
    else return 64'd0;
    if (a[2:0] == 3'd0) return sz ? v : (v & 64'h0000_0000_FFFF_FFFF);
    if (a[2:0] == 3'd4) return v >> 32;
    return 64'd0;
  endfunction

  function automatic logic [63:0] merge(logic [63:0] v, logic [2:0] sub,
                                        logic sz, logic [63:0] d);
    if (sub == 3'd0 && sz)  return d;
    if (sub == 3'd0 && !sz) return {v[63:32], d[31:0]};
    if (sub == 3'd4 && !sz) return {d[31:0], v[31:0]};
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic en, logic we, logic [AW-1:0] a, logic sz,
                      logic [63:0] d, logic tk, string tag);
    logic tw;
    bus_en = en; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d; tick_en = tk;
    #1;
    check(tag, 64'(timer_irq), 64'(irq_m), "irq");
    if (en && !we) check(tag, bus_rdata, m_read(a, sz), "rdata");
    else           check(tag, bus_rdata, 64'd0, "rdata idle");
    @(posedge clk);
    for (int h = 0; h < N; h++) irq_m[h] = (cm[h] <= tm);
    tw = 1'b0;
    if (en && we) begin
      if (a >= CB && a < CB + AW'(N * 8)) begin
        cm[(a - CB) >> 3] = merge(cm[(a - CB) >> 3], a[2:0], sz, d);
      end else if (a[AW-1:3] == TB[AW-1:3]) begin
        tw = (a[2:0] == 3'd0) || (a[2:0] == 3'd4 && !sz);
        tm = merge(tm, a[2:0], sz, d);
      end
    end
    if (!tw && tk) tm = tm + 64'd1;
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic sz, logic [63:0] d, string tag);
    step(1'b1, 1'b1, a, sz, d, 1'b0, tag);
  endtask
  task automatic rd(logic [AW-1:0] a, logic sz, string tag);
    step(1'b1, 1'b0, a, sz, 64'd0, 1'b0, tag);
  endtask
  task automatic idle(int n, logic tk, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, 64'd0, tk, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tm = '0; irq_m = '0;
    for (int h = 0; h < N; h++) cm[h] = ONES;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(TB, 1'b1, "R1");
    rd(CB, 1'b1, "R1");
    rd(CB + 12'd28, 1'b0, "R1");
    // R2 ticking and holding
    idle(10, 1'b1, "R2");
    rd(TB, 1'b1, "R2");
    idle(3, 1'b0, "R2");
    rd(TB, 1'b1, "R2");
    // R3 write beats tick
    step(1'b1, 1'b1, TB, 1'b1, 64'h0000_0001_FFFF_FFF0, 1'b1, "R3");
    rd(TB, 1'b1, "R3");
    // R4 counter half writes
    wr(TB, 1'b0, 64'hAAAA_AAAA_0000_0010, "R4");
    rd(TB, 1'b1, "R4");
    wr(TB + 12'd4, 1'b0, 64'h5555_5555_0000_0002, "R4");
    rd(TB, 1'b1, "R4");
    wr(TB + 12'd4, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF, "R4");
    rd(TB, 1'b1, "R4");
    // R10 half reads
    rd(TB + 12'd4, 1'b0, "R10");
    rd(TB, 1'b0, "R10");
    // R2 carry across halves
    wr(TB, 1'b0, 64'h0000_0000_FFFF_FFFF, "R2");
    idle(2, 1'b1, "R2");
    rd(TB, 1'b1, "R2");
    // R6 compare half writes
    wr(CB + 12'd8, 1'b1, 64'h1234_5678_9ABC_DEF0, "R6");
    wr(CB + 12'd8, 1'b0, 64'h0000_0000_1111_1111, "R6");
    wr(CB + 12'd12, 1'b0, 64'h0000_0000_2222_2222, "R6");
    wr(CB + 12'd12, 1'b1, ONES, "R6");
    rd(CB + 12'd8, 1'b1, "R6");
    rd(CB + 12'd12, 1'b0, "R10");
    // R5 stride and out-of-range slot
    wr(CB + 12'd24, 1'b1, 64'h77, "R5");
    rd(CB + 12'd24, 1'b1, "R5");
    wr(CB + 12'd32, 1'b1, 64'd0, "R5");
    rd(CB + 12'd32, 1'b1, "R5");
    rd(CB, 1'b1, "R5");
    rd(CB + 12'd16, 1'b1, "R5");
    // R9 bad offsets and unmapped addresses
    wr(CB + 12'd2, 1'b0, 64'd0, "R9");
    rd(CB, 1'b1, "R9");
    rd(CB + 12'd2, 1'b0, "R9");
    wr(12'h400, 1'b1, 64'd5, "R9");
    rd(12'h400, 1'b1, "R9");
    rd(TB + 12'd2, 1'b0, "R9");
    rd(TB, 1'b1, "R9");
    // R7 approach and cross the compare value
    wr(TB, 1'b1, 64'd100, "R7");
    wr(CB, 1'b1, 64'd105, "R7");
    idle(8, 1'b1, "R7");
    wr(CB + 12'd16, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, "R7");
    idle(2, 1'b0, "R7");
    wr(TB, 1'b1, 64'h8000_0000_0000_0000, "R7");
    idle(2, 1'b0, "R7");
    // R8 counter jumps re-evaluate every hart
    wr(TB, 1'b1, ONES, "R8");
    idle(2, 1'b0, "R8");
    wr(TB, 1'b1, 64'd0, "R8");
    idle(2, 1'b0, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule